// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block sits behind a clock-and-data recovery front end. It takes the retimed serial bit stream and its bit clock and produces 16-bit parallel words, a parallel clock, and a one-cycle word strobe, all in the bit-clock domain. The bit that arrives first in each word is placed in the most significant position.

Downstream framing logic searches the parallel words for its alignment pattern. When the pattern is misaligned, the framer raises the synchronization input. The input passes through a small synchronizer and is then qualified: it must stay high for a minimum number of bit periods. A qualified pulse discards exactly one serial bit, however long the pulse lasts. Discarding a bit moves the word boundary one position later in the stream. By repeating slips, the framer can reach any of the 16 alignments.

Top module: `serial_deser`

## Requirements
- R1: While reset is high, and at its release, the parallel output is all zeros, the word strobe is low and the parallel clock is high. The bit counter is at zero.
- R2: Every 16 kept serial bits form one word. The earliest kept bit of the word appears on bit 15 and the latest on bit 0.
- R3: After reset is released, the first word is presented at the 16th rising clock edge. It is visible in the cycle that follows that edge.
- R4: The word strobe is high for exactly one cycle each time a new word is loaded. The parallel output does not change in any other cycle.
- R5: The parallel clock rises at the same edge that loads a new word. Between slips, it stays high for 8 cycles and low for 8 cycles.
- R6: The synchronization input is qualified when it is sampled high at 4 consecutive rising edges. Call the first of these edges S. The serial bit sampled at edge S+5 is dropped: it is not placed in any word.
- R7: A synchronization pulse that is sampled high at fewer than 4 consecutive edges has no effect on the output words or on their timing.
- R8: A qualified pulse drops exactly one bit, however long it stays high. Once the input has been sampled low at least once, a new qualified pulse drops another bit.
- R9: On the cycle of a drop, the bit counter holds its value. The word that spans the drop therefore takes 17 cycles to collect, and it takes the next bit from the following slot. All later words keep a 16-cycle spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Retimed serial data, one bit per clock |
| sync_i | input | 1 | Slip request from the framer; may be asynchronous |
| pdata_o | output | 16 | Parallel word; bit 15 holds the earliest bit |
| pclk_o | output | 1 | Parallel clock at 1/16 of the bit rate |
| wstb_o | output | 1 | One-cycle pulse marking a new word |

## Verification
Some behaviours are checked by the embedded properties on every cycle:
- a slip lasts a single cycle;
- the bit counter freezes during a slip;
- strobes never come back to back;
- the parallel word holds between strobes;
- the parallel clock rises only together with a strobe.

Other behaviours can only be shown by the bench scenarios. These cover which bit is dropped, that short pulses are ignored, the MSB-first packing, and the position of the first word after reset. The bench compares every word against a reference stream from which it removes the dropped bits itself.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Defaults shared by the deserializer sub-blocks
    localparam int unsigned WORD_W_DEF      = 16;
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned MIN_SYNC_DEF    = 4;

    // State of the slip-request qualifier
    typedef enum logic [1:0] {
        QUAL_IDLE  = 2'd0,  // waiting for a high level
        QUAL_COUNT = 2'd1,  // measuring pulse width
        QUAL_SPENT = 2'd2   // slip issued, waiting for low level
    } qual_state_e;

    // Counter width for a value range 0..n
    function automatic int unsigned range_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sync_slip_qual.sv
module sync_slip_qual
    import deser_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int unsigned MIN_WIDTH   = MIN_SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic slip_o
);
    localparam int unsigned RUN_W = range_bits(MIN_WIDTH);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   s_high;
    qual_state_e            state_q, state_d;
    logic [RUN_W-1:0]       run_q, run_d;

    // Synchronizer chain, shape chosen by stage count
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= sync_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[SYNC_STAGES-2:0], sync_i};
            end
        end
    endgenerate

    assign s_high = chain_q[SYNC_STAGES-1];

    // Fire on the cycle the width requirement is met
    assign slip_o = (state_q == QUAL_COUNT) && s_high
                    && (run_q == RUN_W'(MIN_WIDTH - 1));

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            QUAL_IDLE: begin
                if (s_high) begin
                    state_d = QUAL_COUNT;
                    run_d   = RUN_W'(1);
                end
            end
            QUAL_COUNT: begin
                if (!s_high) begin
                    state_d = QUAL_IDLE;
                    run_d   = '0;
                end else if (slip_o) begin
                    state_d = QUAL_SPENT;
                end else begin
                    run_d = run_q + RUN_W'(1);
                end
            end
            QUAL_SPENT: begin
                if (!s_high) begin
                    state_d = QUAL_IDLE;
                    run_d   = '0;
                end
            end
            default: begin
                state_d = QUAL_IDLE;
                run_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= QUAL_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // R8
    slip_single_chk: assert property (@(posedge clk) disable iff (rst)
        slip_o |=> !slip_o)
        else $error("slip request lasted more than one cycle");

endmodule

// File: rtl/bit_gather.sv
module bit_gather #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi_i,
    input  logic              slip_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              load_o,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-2:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;

    // Earliest bit ends up at the top after WORD_W shifts
    assign word_o = {sr_q, sdi_i};
    assign load_o = (cnt_q == CNT_W'(WORD_W - 1)) && !slip_i;
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (!slip_i) begin
            sr_q  <= {sr_q[WORD_W-3:0], sdi_i};
            cnt_q <= load_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        slip_i |=> (cnt_q == $past(cnt_q)))
        else $error("bit counter advanced during a slip");

endmodule

// File: rtl/word_port.sv
module word_port #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [WORD_W-1:0] pdata_o,
    output logic              wstb_o,
    output logic              pclk_o
);
    localparam int unsigned HALF = WORD_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pdata_o <= '0;
            wstb_o  <= 1'b0;
        end else begin
            wstb_o <= load_i;
            if (load_i) pdata_o <= word_i;
        end
    end

    // High during the first half of each word period
    assign pclk_o = (cnt_i < CNT_W'(HALF));

    // R4
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        wstb_o |=> !wstb_o)
        else $error("word strobe high on consecutive cycles");

    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wstb_o && !$past(rst)) |-> $stable(pdata_o))
        else $error("parallel word changed without a strobe");

    // R5
    pclk_load_chk: assert property (@(posedge clk) disable iff (rst)
        wstb_o |-> pclk_o)
        else $error("parallel clock low when a word was loaded");

    // R5
    pclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pclk_o) |-> wstb_o)
        else $error("parallel clock rose without a word load");

endmodule

// File: rtl/serial_deser.sv
module serial_deser
    import deser_pkg::*;
#(
    parameter int unsigned WORD_W      = WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int unsigned MIN_SYNC    = MIN_SYNC_DEF
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic              sdi,
    input  logic              sync_i,
    output logic [WORD_W-1:0] pdata_o,
    output logic              pclk_o,
    output logic              wstb_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W);

    logic              slip;
    logic              load;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] word;

    sync_slip_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_WIDTH  (MIN_SYNC)
    ) qual_i (
        .clk   (clk_bit),
        .rst   (rst),
        .sync_i(sync_i),
        .slip_o(slip)
    );

    bit_gather #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) gather_i (
        .clk   (clk_bit),
        .rst   (rst),
        .sdi_i (sdi),
        .slip_i(slip),
        .cnt_o (cnt),
        .load_o(load),
        .word_o(word)
    );

    word_port #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) port_i (
        .clk    (clk_bit),
        .rst    (rst),
        .load_i (load),
        .word_i (word),
        .cnt_i  (cnt),
        .pdata_o(pdata_o),
        .wstb_o (wstb_o),
        .pclk_o (pclk_o)
    );

endmodule

// File: tb/serial_deser_tb.sv
module serial_deser_tb_top;

    localparam int NB   = 200;  // serial bits per vector
    localparam int MINW = 4;    // qualifying width
    localparam int LAT  = 5;    // first high sample to dropped bit
    localparam int NV   = 8;

    typedef struct packed {
        logic [15:0] seed;
        logic [7:0]  start;
        logic [7:0]  width;
        logic [7:0]  gap;
        logic [7:0]  width2;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{16'hACE1, 8'd0,  8'd0,  8'd0, 8'd0},  // plain stream
        '{16'h1234, 8'd40, 8'd4,  8'd0, 8'd0},  // minimum qualified pulse
        '{16'h5A5A, 8'd40, 8'd3,  8'd0, 8'd0},  // too short
        '{16'h0F0F, 8'd30, 8'd40, 8'd0, 8'd0},  // long pulse, one slip
        '{16'h7777, 8'd20, 8'd5,  8'd6, 8'd4},  // two pulses, re-arm
        '{16'h2468, 8'd10, 8'd4,  8'd0, 8'd0},  // drop lands on last bit of word
        '{16'hFFFF, 8'd50, 8'd1,  8'd0, 8'd0},  // one-cycle glitch
        '{16'h9BDF, 8'd58, 8'd6,  8'd0, 8'd0}   // drop at word boundary
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdi = 1'b0;
    logic        sync_in = 1'b0;
    logic [15:0] pdata;
    logic        pclk;
    logic        wstb;

    int n_chk  = 0;
    int n_fail = 0;

    logic bits  [0:NB-1];
    logic syncv [0:NB-1];
    logic kept  [0:NB-1];
    int   nk;
    int   ndrop;

    always #4 clk = ~clk;

    serial_deser dut_i (
        .clk_bit(clk),
        .rst    (rst),
        .sdi    (sdi),
        .sync_i (sync_in),
        .pdata_o(pdata),
        .pclk_o (pclk),
        .wstb_o (wstb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst     = 1'b1;
        sync_in = 1'b0;
        sdi     = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [15:0] x;
        logic [15:0] expw;
        logic [15:0] last;
        int widx, since, prev, n17, p2;
        string tag;
        // build stream and sync pattern
        x = v.seed;
        for (int k = 0; k < NB; k++) begin
            x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
            bits[k]  = x[0];
            syncv[k] = 1'b0;
        end
        for (int k = 0; k < int'(v.width); k++) syncv[v.start + k] = 1'b1;
        p2 = int'(v.start) + int'(v.width) + int'(v.gap);
        for (int k = 0; k < int'(v.width2); k++) syncv[p2 + k] = 1'b1;
        // reference: which bits survive
        ndrop = 0;
        for (int k = 0; k < NB; k++) kept[k] = 1'b1;
        for (int k = 0; k < NB; k++) begin
            if (syncv[k] && (k == 0 || !syncv[k-1])) begin
                int len;
                len = 0;
                while (k + len < NB && syncv[k + len]) len++;
                if (len >= MINW && k + LAT < NB) begin
                    kept[k + LAT] = 1'b0;
                    ndrop++;
                end
            end
        end
        nk = 0;
        for (int k = 0; k < NB; k++) if (kept[k]) nk++;
        if (v.width2 > 0)                    tag = "R8";
        else if (v.width > 0 && v.width < 4) tag = "R7";
        else if (v.width >= 20)              tag = "R8";
        else if (ndrop > 0)                  tag = "R6";
        else                                 tag = "R2";

        do_reset();
        widx = 0; since = 0; prev = -1; n17 = 0; last = 16'h0;
        for (int k = 0; k < NB; k++) begin
            sdi     = bits[k];
            sync_in = syncv[k];
            @(posedge clk);
            @(negedge clk);
            if (wstb) begin
                // expected word from kept bits, earliest on bit 15
                int cnt, pos;
                cnt = 0; pos = 0; expw = 16'h0;
                for (int j = 0; j < NB; j++) begin
                    if (kept[j]) begin
                        if (cnt >= widx * 16 && cnt < widx * 16 + 16) begin
                            expw[15 - pos] = bits[j];
                            pos++;
                        end
                        cnt++;
                    end
                end
                chk(pdata == expw, tag, int'(pdata), int'(expw));
                chk(pclk == 1'b1, "R5 pclk at load", int'(pclk), 1);
                if (widx == 0 && ndrop == 0) chk(k == 15, "R3 first word edge", k, 15);
                chk((k - prev) == 16 || (k - prev) == 17, "R9 strobe spacing", k - prev, 16);
                if ((k - prev) == 17) n17++;
                prev = k;
                widx++;
                since = 0;
                last = pdata;
            end else begin
                since++;
                chk(pdata == last, "R4 hold between strobes", int'(pdata), int'(last));
                if (ndrop == 0 && widx > 0)
                    chk(pclk == (since < 8), "R5 pclk phase", int'(pclk), int'(since < 8));
            end
        end
        chk(widx == nk / 16, "R8 word count", widx, nk / 16);
        chk(n17 == ndrop, "R9 stretched words", n17, ndrop);
        sync_in = 1'b0;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(pdata == 16'h0, "R1 pdata in reset", int'(pdata), 0);
        chk(wstb == 1'b0, "R1 wstb in reset", int'(wstb), 0);
        chk(pclk == 1'b1, "R1 pclk in reset", int'(pclk), 1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1 reset in the middle of traffic
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(pdata == 16'h0, "R1 pdata after mid reset", int'(pdata), 0);
        chk(wstb == 1'b0, "R1 wstb after mid reset", int'(wstb), 0);
        chk(pclk == 1'b1, "R1 pclk after mid reset", int'(pclk), 1);
        // R7 sync held during reset is not honoured before release
        sync_in = 1'b1;
        repeat (2) @(negedge clk);
        sync_in = 1'b0;
        rst = 1'b0;
        repeat (16) begin
            sdi = 1'b1;
            @(negedge clk);
        end
        chk(wstb == 1'b1, "R7 no slip from sync during reset", int'(wstb), 1);
        chk(pdata == 16'hFFFF, "R3 word after reset", int'(pdata), 16'hFFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule